// File: doc/BRIEF.md
# Pulse-Width Symbol Discriminator

This block sits behind the carrier demodulator of an amplitude-keyed timecode receiver. Each bit of such a timecode is carried as a baud of ten carrier cycles, and the bit value is set by how many cycles at the start of the baud are sent at high amplitude. The block receives one signed envelope sample per carrier cycle, qualified by a cycle strobe. It receives both the raw envelope and a smoothed (integrated) envelope. From these it recovers the baud boundaries and reports each baud as a ZERO, ONE or POSITION marker.

Baud alignment uses a 30-cycle history of integrated-envelope bits. Each bit is sliced at the midpoint of the integrated extremes seen in the previous baud. A masked compare against a fixed marker pattern in that history forces the baud boundary. The symbol value uses a separate history of raw-envelope bits, sliced against a level that is recomputed at every boundary. At the boundary, the eight most recent raw bits must exactly match one of the legal high-run shapes. Any other shape is reported as a ZERO and raises a sticky decode-error flag. A realignment that moves the boundary raises a sticky sync-error flag.

Top module: `pwsd_top`

## Requirements
- R1: After reset all outputs are low, both error flags are clear, the cycle position is 0, the slice level is 0 and both shift histories are zero.
- R2: Each cycle strobe advances the cycle position by one, wrapping from 9 to 0. `sym_valid` and `baud_stb` pulse high for exactly one clock after each strobe that brings the position to 0, and stay low after every other strobe and on clocks without a strobe.
- R3: On each strobe a raw bit enters the data history. It is 1 when `env_raw` is greater than or equal to the current slice level, so a sample equal to the level counts as high.
- R4: The slice level changes only on a boundary strobe. It becomes the floor of half the sum of two values. The first is the largest raw sample taken at positions 1 and 2. The second is the smallest raw sample taken at position 9 and at the boundary strobe itself. The result is rounded toward minus infinity.
- R5: At a boundary, the eight newest data bits form a byte. Bit 0 is the boundary cycle and bit 7 is the cycle at position 3. The byte maps to a symbol code: 0x00 and 0x80 give ZERO (code 0); 0xC0, 0xE0 and 0xF0 give ONE (code 1); 0xF8, 0xFC and 0xFE give POSITION (code 2).
- R6: Any other byte at a boundary is reported with code 0 (ZERO) and sets `dec_err`.
- R7: The raw bits taken at positions 1 and 2 of a baud have no effect on the reported symbol.
- R8: On each strobe an alignment bit enters a 30-bit history. It is 1 when `env_int` is greater than or equal to the floor of the midpoint of the integrated maximum and minimum latched at the previous boundary (0 and 0 after reset).
- R9: When the alignment history ANDed with 0x303C0F03 equals 0x300C0300, the position is forced to 0 and the strobe is treated as a boundary. If the position would not otherwise have become 0, `sync_err` is set.
- R10: `dec_err` and `sync_err` stay set until `err_clr` is high on a clock. If an error event occurs in the same clock as `err_clr`, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_stb | input | 1 | One-clock strobe, one per carrier cycle |
| env_raw | input | 16 | Signed raw envelope sample for this cycle |
| env_int | input | 16 | Signed integrated envelope sample for this cycle |
| err_clr | input | 1 | Clears both sticky error flags |
| sym_code | output | 2 | Last symbol: 0 ZERO, 1 ONE, 2 POSITION |
| sym_valid | output | 1 | One-clock pulse qualifying `sym_code` |
| baud_stb | output | 1 | One-clock pulse at each baud boundary |
| dec_err | output | 1 | Sticky flag for an illegal run pattern |
| sync_err | output | 1 | Sticky flag for a realignment that moved the boundary |

## Verification
The assertions assume that the envelope inputs only matter on strobe clocks. They also assume that an error flag can rise only together with a boundary pulse, so the stimulus keeps `err_clr` separate from boundaries except in the one case that tests its priority.

The stimulus spaces strobes two clocks apart and uses envelope levels of ±1000 with high cycles at positions 1 and 2. This keeps the slice level at exactly 0 or 1000, so every raw bit is the one intended. The integrated stream always carries both levels inside each baud window, so the alignment threshold stays at the midpoint. Separate bauds with chosen levels probe the inclusive compare and the floor rounding of the slice midpoint.

// File: rtl/pwsd_pkg.sv
package pwsd_pkg;

  typedef enum logic [1:0] {
    SYM_ZERO = 2'd0,
    SYM_ONE  = 2'd1,
    SYM_POS  = 2'd2
  } sym_e;

  localparam int ENV_W_DEF    = 16;
  localparam int BAUD_LEN_DEF = 10;
  localparam int ALIGN_W_DEF  = 30;
  localparam int CLASS_W_DEF  = 8;

endpackage

// File: rtl/pwsd_align.sv
module pwsd_align #(
  parameter int ENV_W    = 16,
  parameter int BAUD_LEN = 10,
  parameter int ALIGN_W  = 30,
  parameter logic [ALIGN_W-1:0] ALIGN_MASK = 30'h303C0F03,
  parameter logic [ALIGN_W-1:0] ALIGN_VAL  = 30'h300C0300,
  localparam int POS_W   = $clog2(BAUD_LEN)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cyc_stb,
  input  logic signed [ENV_W-1:0] env_int,
  output logic [POS_W-1:0]        pos_q,
  output logic [POS_W-1:0]        pos_next,
  output logic                    bnd,
  output logic                    sync_evt
);

  localparam logic signed [ENV_W-1:0] ENV_MAX = {1'b0, {(ENV_W-1){1'b1}}};
  localparam logic signed [ENV_W-1:0] ENV_MIN = {1'b1, {(ENV_W-1){1'b0}}};
  localparam logic [POS_W-1:0]        LAST_POS = POS_W'(BAUD_LEN - 1);

  logic [ALIGN_W-1:0]        hist_q;
  logic [ALIGN_W-1:0]        hist_next;
  logic signed [ENV_W-1:0]   run_max_q, run_min_q;
  logic signed [ENV_W-1:0]   lat_max_q, lat_min_q;
  logic signed [ENV_W-1:0]   cur_max, cur_min;
  logic signed [ENV_W:0]     ext_sum;
  logic signed [ENV_W:0]     thr;
  logic signed [ENV_W:0]     env_ext;
  logic                      abit;
  logic                      hit;
  logic [POS_W-1:0]          pos_inc;

  // threshold from previous baud's integrated extremes
  assign ext_sum = $signed({lat_max_q[ENV_W-1], lat_max_q}) +
                   $signed({lat_min_q[ENV_W-1], lat_min_q});
  assign thr     = ext_sum >>> 1;
  assign env_ext = $signed({env_int[ENV_W-1], env_int});
  assign abit    = (env_ext >= thr);

  assign hist_next = {hist_q[ALIGN_W-2:0], abit};
  assign hit       = ((hist_next & ALIGN_MASK) == ALIGN_VAL);
  assign pos_inc   = (pos_q == LAST_POS) ? '0 : pos_q + POS_W'(1);
  assign pos_next  = hit ? '0 : pos_inc;
  assign bnd       = cyc_stb && (pos_next == '0);
  assign sync_evt  = cyc_stb && hit && (pos_inc != '0);

  assign cur_max = (env_int > run_max_q) ? env_int : run_max_q;
  assign cur_min = (env_int < run_min_q) ? env_int : run_min_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q    <= '0;
      pos_q     <= '0;
      run_max_q <= ENV_MIN;
      run_min_q <= ENV_MAX;
      lat_max_q <= '0;
      lat_min_q <= '0;
    end else if (cyc_stb) begin
      hist_q <= hist_next;
      pos_q  <= pos_next;
      if (pos_next == '0) begin
        lat_max_q <= cur_max;
        lat_min_q <= cur_min;
        run_max_q <= ENV_MIN;
        run_min_q <= ENV_MAX;
      end else begin
        run_max_q <= cur_max;
        run_min_q <= cur_min;
      end
    end
  end

  // R2: position never leaves the baud range
  a_r2_pos_in_range: assert property (@(posedge clk) disable iff (rst)
    pos_q <= LAST_POS);

  // R2: position only moves on a strobe
  a_r2_pos_hold: assert property (@(posedge clk) disable iff (rst)
    !cyc_stb |=> $stable(pos_q));

  // R9: a marker hit always lands on position 0
  a_r9_hit_aligns: assert property (@(posedge clk) disable iff (rst)
    (cyc_stb && hit) |=> (pos_q == '0));

endmodule

// File: rtl/pwsd_slicer.sv
module pwsd_slicer #(
  parameter int ENV_W    = 16,
  parameter int BAUD_LEN = 10,
  parameter int DATA_W   = 10,
  localparam int POS_W   = $clog2(BAUD_LEN)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cyc_stb,
  input  logic signed [ENV_W-1:0] env_raw,
  input  logic [POS_W-1:0]        pos_next,
  input  logic                    bnd,
  output logic [DATA_W-1:0]       data_next,
  output logic signed [ENV_W-1:0] slice_q
);

  localparam logic signed [ENV_W-1:0] ENV_MAX  = {1'b0, {(ENV_W-1){1'b1}}};
  localparam logic signed [ENV_W-1:0] ENV_MIN  = {1'b1, {(ENV_W-1){1'b0}}};
  localparam logic [POS_W-1:0]        POS_PK0  = POS_W'(1);
  localparam logic [POS_W-1:0]        POS_PK1  = POS_W'(2);
  localparam logic [POS_W-1:0]        POS_TRGH = POS_W'(BAUD_LEN - 1);

  logic [DATA_W-1:0]         data_q;
  logic signed [ENV_W-1:0]   emax_q, emin_q;
  logic signed [ENV_W-1:0]   fin_min;
  logic signed [ENV_W:0]     mid_sum;
  logic signed [ENV_W:0]     mid;
  logic                      dbit;

  assign dbit      = (env_raw >= slice_q);
  assign data_next = {data_q[DATA_W-2:0], dbit};
  assign fin_min   = (env_raw < emin_q) ? env_raw : emin_q;
  assign mid_sum   = $signed({emax_q[ENV_W-1], emax_q}) +
                     $signed({fin_min[ENV_W-1], fin_min});
  assign mid       = mid_sum >>> 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      slice_q <= '0;
      emax_q  <= ENV_MIN;
      emin_q  <= ENV_MAX;
    end else if (cyc_stb) begin
      data_q <= data_next;
      if (pos_next == '0) begin
        slice_q <= mid[ENV_W-1:0];
        emax_q  <= ENV_MIN;
        emin_q  <= ENV_MAX;
      end else if (pos_next == POS_PK0) begin
        emax_q <= env_raw;
      end else if (pos_next == POS_PK1) begin
        if (env_raw > emax_q) emax_q <= env_raw;
      end else if (pos_next == POS_TRGH) begin
        emin_q <= env_raw;
      end
    end
  end

  // R4: slice level is only rewritten at a boundary strobe
  a_r4_slice_only_at_boundary: assert property (@(posedge clk) disable iff (rst)
    !bnd |=> $stable(slice_q));

endmodule

// File: rtl/pwsd_classify.sv
module pwsd_classify
  import pwsd_pkg::*;
#(
  parameter int CLASS_W = 8,
  parameter int ONE_RUN = 2,
  parameter int POS_RUN = 5,
  localparam int RUN_W  = $clog2(CLASS_W + 1)
) (
  input  logic [CLASS_W-1:0] pat,
  output sym_e               sym,
  output logic               bad
);

  logic [CLASS_W:0]   shape_hit;
  logic [RUN_W-1:0]   run;
  logic               any_hit;

  // one comparator per legal high-run length (thermometer shape)
  for (genvar g = 0; g <= CLASS_W; g++) begin : g_shape
    localparam logic [CLASS_W-1:0] SHAPE = ~({CLASS_W{1'b1}} >> g);
    assign shape_hit[g] = (pat == SHAPE);
  end

  always_comb begin
    run     = '0;
    any_hit = 1'b0;
    for (int i = 0; i <= CLASS_W; i++) begin
      if (shape_hit[i]) begin
        run     = RUN_W'(i);
        any_hit = 1'b1;
      end
    end
  end

  always_comb begin
    bad = !any_hit || (run == RUN_W'(CLASS_W));
    sym = SYM_ZERO;
    if (!bad) begin
      if (run >= RUN_W'(POS_RUN))      sym = SYM_POS;
      else if (run >= RUN_W'(ONE_RUN)) sym = SYM_ONE;
      else                             sym = SYM_ZERO;
    end
  end

  // R6: an illegal shape always maps to ZERO
  always_comb begin
    a_r6_bad_is_zero: assert (!bad || sym == SYM_ZERO);
  end

endmodule

// File: rtl/pwsd_top.sv
module pwsd_top
  import pwsd_pkg::*;
#(
  parameter int ENV_W    = ENV_W_DEF,
  parameter int BAUD_LEN = BAUD_LEN_DEF,
  parameter int ALIGN_W  = ALIGN_W_DEF,
  parameter int CLASS_W  = CLASS_W_DEF,
  parameter logic [ALIGN_W-1:0] ALIGN_MASK = 30'h303C0F03,
  parameter logic [ALIGN_W-1:0] ALIGN_VAL  = 30'h300C0300
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_stb,
  input  logic [ENV_W-1:0] env_raw,
  input  logic [ENV_W-1:0] env_int,
  input  logic             err_clr,
  output logic [1:0]       sym_code,
  output logic             sym_valid,
  output logic             baud_stb,
  output logic             dec_err,
  output logic             sync_err
);

  localparam int POS_W  = $clog2(BAUD_LEN);
  localparam int DATA_W = BAUD_LEN;

  logic [POS_W-1:0]        pos_q, pos_next;
  logic                    bnd, sync_evt;
  logic [DATA_W-1:0]       data_next;
  logic signed [ENV_W-1:0] slice_q;
  sym_e                    cls_sym;
  logic                    cls_bad;

  pwsd_align #(
    .ENV_W(ENV_W), .BAUD_LEN(BAUD_LEN), .ALIGN_W(ALIGN_W),
    .ALIGN_MASK(ALIGN_MASK), .ALIGN_VAL(ALIGN_VAL)
  ) u_align (
    .clk(clk), .rst(rst), .cyc_stb(cyc_stb),
    .env_int($signed(env_int)),
    .pos_q(pos_q), .pos_next(pos_next), .bnd(bnd), .sync_evt(sync_evt)
  );

  pwsd_slicer #(
    .ENV_W(ENV_W), .BAUD_LEN(BAUD_LEN), .DATA_W(DATA_W)
  ) u_slicer (
    .clk(clk), .rst(rst), .cyc_stb(cyc_stb),
    .env_raw($signed(env_raw)),
    .pos_next(pos_next), .bnd(bnd),
    .data_next(data_next), .slice_q(slice_q)
  );

  pwsd_classify #(
    .CLASS_W(CLASS_W)
  ) u_classify (
    .pat(data_next[CLASS_W-1:0]), .sym(cls_sym), .bad(cls_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sym_code  <= 2'd0;
      sym_valid <= 1'b0;
      baud_stb  <= 1'b0;
      dec_err   <= 1'b0;
      sync_err  <= 1'b0;
    end else begin
      sym_valid <= bnd;
      baud_stb  <= bnd;
      if (bnd) sym_code <= cls_sym;
      if (bnd && cls_bad) dec_err <= 1'b1;
      else if (err_clr)   dec_err <= 1'b0;
      if (sync_evt)       sync_err <= 1'b1;
      else if (err_clr)   sync_err <= 1'b0;
    end
  end

  // R2: a symbol pulse only follows a strobe
  a_r2_valid_after_strobe: assert property (@(posedge clk) disable iff (rst)
    sym_valid |-> $past(cyc_stb));

  // R5: only the three defined codes ever appear
  a_r5_code_legal: assert property (@(posedge clk) disable iff (rst)
    sym_valid |-> (sym_code != 2'd3));

  // R6: decode error can only rise with a symbol
  a_r6_dec_rise_at_boundary: assert property (@(posedge clk) disable iff (rst)
    $rose(dec_err) |-> sym_valid);

  // R9: sync error can only rise with a boundary pulse
  a_r9_sync_rise_at_boundary: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_err) |-> baud_stb);

  // R10: flags hold unless cleared
  a_r10_dec_sticky: assert property (@(posedge clk) disable iff (rst)
    ($past(dec_err) && !$past(err_clr)) |-> dec_err);

  a_r10_sync_sticky: assert property (@(posedge clk) disable iff (rst)
    ($past(sync_err) && !$past(err_clr)) |-> sync_err);

endmodule

// File: tb/pwsd_top_bench.sv
`timescale 1ns/1ps
module pwsd_top_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        cyc_stb;
  logic [15:0] env_raw, env_int;
  logic        err_clr;
  logic [1:0]  sym_code;
  logic        sym_valid, baud_stb, dec_err, sync_err;

  int checks = 0;
  int fails  = 0;
  logic signed [15:0] lvl [0:9];

  always #4 clk = ~clk;

  pwsd_top u_pwsd_top (
    .clk(clk), .rst(rst), .cyc_stb(cyc_stb), .env_raw(env_raw),
    .env_int(env_int), .err_clr(err_clr), .sym_code(sym_code),
    .sym_valid(sym_valid), .baud_stb(baud_stb), .dec_err(dec_err),
    .sync_err(sync_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; cyc_stb = 1'b0; err_clr = 1'b0; env_raw = '0; env_int = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic strobe(input logic signed [15:0] raw, input logic signed [15:0] integ,
                        input bit clr, output logic v, output logic b, output logic [1:0] c);
    @(negedge clk);
    env_raw = raw; env_int = integ; cyc_stb = 1'b1; err_clr = clr;
    @(negedge clk);
    cyc_stb = 1'b0; err_clr = 1'b0;
    v = sym_valid; b = baud_stb; c = sym_code;
  endtask

  // run positions 1..9 then 0 using lvl[], integrated input held at 0
  task automatic run_baud(input bit clr_last, output logic [1:0] code, output logic vb);
    logic v, b;
    logic [1:0] c;
    int mid_pulses;
    mid_pulses = 0;
    code = 2'd0;
    vb = 1'b0;
    for (int p = 1; p <= 10; p++) begin
      strobe(lvl[p % 10], 16'sd0, clr_last && (p == 10), v, b, c);
      if (p < 10) begin
        if (v || b) mid_pulses++;
      end else begin
        code = c;
        vb = v && b;
      end
    end
    chk(mid_pulses == 0, "R2 no pulse inside baud", mid_pulses, 0);
  endtask

  // byte bit7 = position 3 ... bit1 = position 9, bit0 = boundary cycle
  task automatic set_pat(input logic [7:0] pat, input bit hi1, input bit hi2);
    lvl[1] = hi1 ? 16'sd1000 : -16'sd1000;
    lvl[2] = hi2 ? 16'sd1000 : -16'sd1000;
    for (int k = 3; k <= 9; k++) lvl[k] = pat[10-k] ? 16'sd1000 : -16'sd1000;
    lvl[0] = pat[0] ? 16'sd1000 : -16'sd1000;
  endtask

  task automatic fill(input logic signed [15:0] val);
    for (int k = 0; k < 10; k++) lvl[k] = val;
  endtask

  task automatic pulse_clr();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask

  function automatic int exp_code(input logic [7:0] pat);
    case (pat)
      8'h00, 8'h80:         return 0;
      8'hC0, 8'hE0, 8'hF0:  return 1;
      8'hF8, 8'hFC, 8'hFE:  return 2;
      default:              return 0;
    endcase
  endfunction

  function automatic bit exp_bad(input logic [7:0] pat);
    case (pat)
      8'h00, 8'h80, 8'hC0, 8'hE0, 8'hF0, 8'hF8, 8'hFC, 8'hFE: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  initial begin
    #(8.0 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [1:0] code;
    logic vb, v, b;
    logic [1:0] c;

    do_reset();
    // R1: reset state
    chk(sym_valid == 0 && baud_stb == 0, "R1 pulses low", int'({sym_valid, baud_stb}), 0);
    chk(dec_err == 0 && sync_err == 0, "R1 flags clear", int'({dec_err, sync_err}), 0);
    chk(sym_code == 0, "R1 code zero", sym_code, 0);

    // R1/R2: first boundary on tenth strobe after reset
    set_pat(8'hC0, 1, 1);
    run_baud(0, code, vb);
    chk(vb == 1, "R2 boundary pulse on tenth strobe", vb, 1);
    chk(code == 1, "R1 first baud ONE", code, 1);
    @(negedge clk);
    chk(sym_valid == 0 && baud_stb == 0, "R2 pulse one clock wide", int'({sym_valid, baud_stb}), 0);

    // R5/R6: sweep every byte
    for (int p = 0; p < 256; p++) begin
      set_pat(8'(p), 1, 1);
      run_baud(0, code, vb);
      chk(vb == 1, "R2 boundary each baud", vb, 1);
      chk(code == 2'(exp_code(8'(p))), exp_bad(8'(p)) ? "R6 code on illegal shape" : "R5 symbol code",
          code, exp_code(8'(p)));
      chk(dec_err == exp_bad(8'(p)), "R6 decode error flag", dec_err, int'(exp_bad(8'(p))));
      if (dec_err) begin
        pulse_clr();
        chk(dec_err == 0, "R10 clear works", dec_err, 0);
      end
    end

    // R7: cycles 1 and 2 do not affect the symbol
    set_pat(8'hF8, 1, 0);
    run_baud(0, code, vb);
    chk(code == 2 && dec_err == 0, "R7 pos2 low keeps POSITION", code, 2);
    set_pat(8'h00, 0, 1);
    run_baud(0, code, vb);
    chk(code == 0 && dec_err == 0, "R7 pos1 low keeps ZERO", int'({dec_err, code}), 0);

    // R4: slice from max(pos1,pos2) and min(pos9,boundary)
    fill(-16'sd1000);
    lvl[1] = 16'sd500; lvl[2] = 16'sd700; lvl[9] = -16'sd300; lvl[0] = -16'sd100;
    run_baud(0, code, vb);
    chk(code == 0, "R4 setup baud ZERO", code, 0);
    // slice now 200; R3 inclusive compare
    fill(-16'sd1000);
    lvl[1] = 16'sd700; lvl[2] = 16'sd700; lvl[3] = 16'sd200; lvl[4] = 16'sd200;
    lvl[9] = -16'sd300; lvl[0] = -16'sd300;
    run_baud(0, code, vb);
    chk(code == 1 && dec_err == 0, "R3 equal to slice counts high", code, 1);
    lvl[4] = 16'sd199;
    run_baud(0, code, vb);
    chk(code == 0 && dec_err == 0, "R3 below slice counts low", int'({dec_err, code}), 0);
    for (int k = 3; k <= 7; k++) lvl[k] = 16'sd200;
    run_baud(0, code, vb);
    chk(code == 2 && dec_err == 0, "R4 slice held at 200", code, 2);
    // R4 rounding toward minus infinity: (700 + -901) / 2 -> -101
    fill(-16'sd1000);
    lvl[1] = 16'sd700; lvl[2] = 16'sd700; lvl[9] = -16'sd901; lvl[0] = -16'sd901;
    run_baud(0, code, vb);
    fill(-16'sd1000);
    lvl[1] = 16'sd1000; lvl[2] = 16'sd1000;
    for (int k = 3; k <= 6; k++) lvl[k] = -16'sd101;
    lvl[7] = -16'sd102;
    run_baud(0, code, vb);
    chk(code == 1 && dec_err == 0, "R4 floor rounding of slice", code, 1);
    set_pat(8'h00, 1, 1);
    run_baud(0, code, vb);

    // R10: sticky and priority
    set_pat(8'h55, 1, 1);
    run_baud(0, code, vb);
    chk(dec_err == 1, "R6 illegal sets flag", dec_err, 1);
    set_pat(8'hE0, 1, 1);
    run_baud(0, code, vb);
    chk(dec_err == 1 && code == 1, "R10 flag sticky over clean baud", dec_err, 1);
    pulse_clr();
    chk(dec_err == 0, "R10 cleared", dec_err, 0);
    set_pat(8'h81, 1, 1);
    run_baud(1, code, vb);
    chk(dec_err == 1, "R10 event wins over clear", dec_err, 1);

    // R8/R9: alignment already matching natural boundaries
    do_reset();
    for (int n = 1; n <= 50; n++) begin
      int k;
      k = n - 1;
      strobe(16'sd0, ((k % 10) < 2) ? 16'sd1000 : -16'sd1000, 0, v, b, c);
      chk(b == ((n % 10) == 0), "R9 aligned boundaries", b, int'((n % 10) == 0));
    end
    chk(sync_err == 0, "R9 no sync error when aligned", sync_err, 0);

    // R8/R9: marker lands mid-baud at strobe 39
    do_reset();
    for (int n = 1; n <= 60; n++) begin
      bit eb;
      eb = (n == 10) || (n == 20) || (n == 30) || (n >= 39 && ((n - 39) % 10) == 0);
      strobe(16'sd0, ((n % 10) < 2) ? 16'sd1000 : -16'sd1000, 0, v, b, c);
      chk(b == eb, "R9 forced boundary timing", b, int'(eb));
      chk(sync_err == (n >= 39), "R9 sync error flag", sync_err, int'(n >= 39));
    end
    pulse_clr();
    chk(sync_err == 0, "R10 sync flag cleared", sync_err, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule